// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Port (Chip-Select Mode with Completion Flag)

This block is the digital side of a 14-bit successive-approximation converter's serial port when it runs in four-wire chip-select mode with a completion flag. It watches three host lines: a convert strobe, a select line and a serial clock. All three are sampled on the block's own system clock. The block drives a data pin that can be released, and it presents that pin as a separate data bit and enable bit.

A conversion begins when the convert strobe rises while the select line is high. The conversion lasts a set number of system clocks. During that time the data pin is released. When the conversion ends with the select line low, the block captures the 14-bit result offered on its result input and pulls the data pin low as a completion flag. A host can use that low level as an interrupt. Each later falling edge of the serial clock then presents the next result bit, most significant first. A fifteenth falling edge ends the frame, and so does the select line rising, whichever comes first. Either way the pin is released and the block returns to acquisition.

Top module: `sar_port`

## Requirements
- R1: In acquisition, a rising convert strobe sampled while the select line is high starts a conversion. The data pin stays released (enable 0) for exactly CONV_CYCLES system clocks after the clock that sees the edge.
- R2: In acquisition, the pin is driven low (enable 1, data 0) whenever the convert strobe and the select line are both low. For any other combination the pin is released.
- R3: A rising convert strobe sampled while the select line is low starts no conversion, so no completion flag ever follows it.
- R4: A conversion that ends with the select line low drives the pin low (enable 1, data 0). The pin stays low until the first falling serial-clock edge.
- R5: A conversion that ends with the select line high gives no completion flag. The pin stays released, and serial-clock edges that follow drive nothing.
- R6: Falling serial-clock edge k, for k from 1 to 14, presents result bit 14-k, where bit 13 is the most significant. Rising serial-clock edges leave the pin unchanged.
- R7: The fifteenth falling serial-clock edge of a frame releases the pin and returns the block to acquisition.
- R8: The select line rising during the completion flag or during shifting releases the pin on the next clock. This holds even when a serial-clock falling edge is seen in the same clock.
- R9: During and right after reset the pin is released and the block is in acquisition.
- R10: The result word is captured in the clock in which the conversion ends. Changes on the result input after that clock do not affect the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all host lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_i | input | 1 | Convert strobe from the host |
| csel_i | input | 1 | Select line from the host; high at the strobe selects this mode |
| sclk_i | input | 1 | Serial clock from the host |
| data_word_i | input | DATA_W | Conversion result, captured at the end of conversion |
| dout_o | output | 1 | Data pin level when enabled |
| dout_en_o | output | 1 | Data pin drive enable; 0 means released (high impedance) |

## Verification
The bench builds the port with a conversion length of 5 clocks, so it can check every clock of the conversion window individually. It keeps the 14-bit word width, so each frame uses all fifteen falling edges. It runs 1024 frames whose result words step through the code space by an odd stride. Across those frames, the point at which the select line ends the frame sweeps every position from the completion flag to the fourteenth bit. For some of those early stops, the select rise lands in the same clock as a serial-clock fall.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    typedef enum logic [1:0] {
        ST_ACQ   = 2'd0,
        ST_CONV  = 2'd1,
        ST_READY = 2'd2,
        ST_SHIFT = 2'd3
    } port_state_e;

endpackage

// File: rtl/sar_port_edges.sv
module sar_port_edges #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] prev_o
);
    // One delay stage per host line; left without reset so the copy
    // always equals the value seen at the previous clock edge.
    for (genvar g = 0; g < N; g++) begin : g_line
        logic prev_q;
        always_ff @(posedge clk) begin
            prev_q <= line_i[g];
        end
        assign prev_o[g] = prev_q;
    end
endmodule

// File: rtl/sar_port_bitsel.sv
module sar_port_bitsel #(
    parameter int W  = 14,
    parameter int IW = 4
) (
    input  logic [W-1:0]  word_i,
    input  logic [IW-1:0] idx_i,
    output logic          bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (idx_i == IW'(i)) begin
                bit_o = word_i[i];
            end
        end
    end
endmodule

// File: rtl/sar_port.sv
module sar_port
    import sar_port_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int CONV_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_i,
    input  logic              csel_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] data_word_i,
    output logic              dout_o,
    output logic              dout_en_o
);
    localparam int CNT_MAX = (CONV_CYCLES > DATA_W) ? CONV_CYCLES : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        port_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] word;
        logic              oe;
        logic              dat;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0] prev;
    logic       conv_rise, csel_rise, sclk_fall;
    logic [CNT_W-1:0] sel_idx;
    logic             sel_bit;

    sar_port_edges #(.N(3)) u_edges (
        .clk    (clk),
        .line_i ({sclk_i, csel_i, conv_i}),
        .prev_o (prev)
    );

    assign conv_rise = conv_i & ~prev[0];
    assign csel_rise = csel_i & ~prev[1];
    assign sclk_fall = ~sclk_i & prev[2];

    // Bit to present next: MSB on leaving the flag, else one below current.
    assign sel_idx = (r_q.st == ST_READY) ? CNT_W'(DATA_W - 1) : (r_q.cnt - 1'b1);

    sar_port_bitsel #(.W(DATA_W), .IW(CNT_W)) u_bitsel (
        .word_i (r_q.word),
        .idx_i  (sel_idx),
        .bit_o  (sel_bit)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_ACQ: begin
                r_d.oe  = ~conv_i & ~csel_i;
                r_d.dat = 1'b0;
                if (conv_rise && csel_i) begin
                    r_d.st  = ST_CONV;
                    r_d.cnt = CNT_W'(CONV_CYCLES - 1);
                    r_d.oe  = 1'b0;
                end
            end
            ST_CONV: begin
                r_d.oe = 1'b0;
                if (r_q.cnt == '0) begin
                    r_d.word = data_word_i;
                    if (!csel_i) begin
                        r_d.st  = ST_READY;
                        r_d.oe  = 1'b1;
                        r_d.dat = 1'b0;
                    end else begin
                        r_d.st = ST_ACQ;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_READY: begin
                if (csel_rise) begin
                    r_d.st = ST_ACQ;
                    r_d.oe = 1'b0;
                end else if (sclk_fall) begin
                    r_d.st  = ST_SHIFT;
                    r_d.cnt = CNT_W'(DATA_W - 1);
                    r_d.dat = sel_bit;
                end
            end
            ST_SHIFT: begin
                if (csel_rise) begin
                    r_d.st = ST_ACQ;
                    r_d.oe = 1'b0;
                end else if (sclk_fall) begin
                    if (r_q.cnt == '0) begin
                        r_d.st = ST_ACQ;
                        r_d.oe = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                        r_d.dat = sel_bit;
                    end
                end
            end
            default: r_d.st = ST_ACQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_ACQ;
            r_q.cnt  <= '0;
            r_q.word <= '0;
            r_q.oe   <= 1'b0;
            r_q.dat  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout_o    = r_q.dat;
    assign dout_en_o = r_q.oe;
endmodule

// File: rtl/sar_port_chk.sv
module sar_port_chk
    import sar_port_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        conv_i,
    input logic        csel_i,
    input logic        dout_o,
    input logic        dout_en_o,
    input port_state_e st_q
);
    assert_conv_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACQ && $rose(conv_i) && csel_i) |=> (st_q == ST_CONV && !dout_en_o));

    assert_conv_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONV) |-> !dout_en_o);

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACQ && !conv_i && !csel_i) |=> (dout_en_o && !dout_o));

    assert_flag_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY) |-> (dout_en_o && !dout_o));

    assert_sel_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_READY || st_q == ST_SHIFT) && $rose(csel_i)) |=> (st_q == ST_ACQ && !dout_en_o));
endmodule

bind sar_port sar_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_i    (conv_i),
    .csel_i    (csel_i),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o),
    .st_q      (r_q.st)
);

// File: tb/sar_port_tb.sv
`timescale 1ns/1ps
module sar_port_tb;
    localparam int DW = 14;
    localparam int CC = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv = 1'b0;
    logic          csel = 1'b0;
    logic          sclk = 1'b0;
    logic [DW-1:0] word = '0;
    logic          dout, dout_en;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    sar_port #(.DATA_W(DW), .CONV_CYCLES(CC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_i      (conv),
        .csel_i      (csel),
        .sclk_i      (sclk),
        .data_word_i (word),
        .dout_o      (dout),
        .dout_en_o   (dout_en)
    );

    task automatic chk(input string req, input logic exp_en, input logic exp_d);
        n_chk++;
        if (dout_en !== exp_en || (exp_en && dout !== exp_d)) begin
            n_fail++;
            $display("FAIL %s: en=%b d=%b expected en=%b d=%b at %0t",
                     req, dout_en, dout, exp_en, exp_d, $time);
        end
    endtask

    // stop_at < 15: raise select after that many falling edges.
    task automatic run_frame(input logic [DW-1:0] v, input int stop_at, input bit same_cycle);
        logic exp_en, exp_d;
        word = v;
        @(negedge clk); conv = 1'b1;
        @(negedge clk); csel = 1'b0;
        chk("R1", 1'b0, 1'b0);
        for (int k = 2; k <= CC; k++) begin
            @(negedge clk); chk("R1", 1'b0, 1'b0);
        end
        @(negedge clk); chk("R4", 1'b1, 1'b0);
        word = ~v;  // R10: late change must not reach the frame
        @(negedge clk); chk("R4", 1'b1, 1'b0);
        exp_en = 1'b1; exp_d = 1'b0;
        for (int e = 1; e <= 15; e++) begin
            if (e == stop_at + 1) begin
                if (same_cycle) begin
                    sclk = 1'b1;
                    @(negedge clk); sclk = 1'b0; csel = 1'b1;
                end else begin
                    csel = 1'b1;
                end
                @(negedge clk); chk("R8", 1'b0, 1'b0);
                break;
            end
            sclk = 1'b1;
            @(negedge clk); chk("R6 rising", exp_en, exp_d);
            sclk = 1'b0;
            @(negedge clk);
            if (e <= DW) begin
                exp_d = v[DW - e];
                chk("R6 R10", 1'b1, exp_d);
            end else begin
                exp_en = 1'b0;
                chk("R7", 1'b0, 1'b0);
            end
        end
        sclk = 1'b0; csel = 1'b1;
        @(negedge clk); conv = 1'b0;
        @(negedge clk); chk("R2 idle", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk); chk("R9 after reset", 1'b1, 1'b0);   // both lines low: R2
        csel = 1'b1;
        @(negedge clk); chk("R2 sel high", 1'b0, 1'b0);
        csel = 1'b0;
        @(negedge clk); chk("R2 both low", 1'b1, 1'b0);
        conv = 1'b1;  // rising strobe with select low
        @(negedge clk); chk("R2 conv high", 1'b0, 1'b0);
        for (int k = 0; k < CC + 4; k++) begin
            @(negedge clk); chk("R3", 1'b0, 1'b0);
        end
        conv = 1'b0;
        @(negedge clk); chk("R2 both low", 1'b1, 1'b0);
        csel = 1'b1;
        @(negedge clk);

        // R5: select stays high across the end of conversion
        word = 14'h2AAA;
        conv = 1'b1;
        for (int k = 0; k < CC + 4; k++) begin
            @(negedge clk); chk("R5", 1'b0, 1'b0);
        end
        for (int e = 0; e < 3; e++) begin
            sclk = 1'b1; @(negedge clk);
            sclk = 1'b0; @(negedge clk); chk("R5 sclk", 1'b0, 1'b0);
        end
        conv = 1'b0;
        @(negedge clk);

        run_frame(14'h0000, 15, 1'b0);
        run_frame(14'h3FFF, 15, 1'b0);
        for (int b = 0; b < DW; b++) run_frame(DW'(1) << b, 15, 1'b0);
        for (int i = 0; i < 1024; i++) begin
            run_frame(DW'((i * 4099 + 7) % 16384), i % 16, (i % 3) == 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule